// File: doc/BRIEF.md
# Interrupt Flag and Mask Controller

This block gathers interrupt events from five peripheral groups (a programmable timer, a serial interface, a key input port, a clock timer and a stopwatch timer). Each event bit is captured in a sticky request flag and paired with an enable bit. Software reaches the enable bits and the request flags through a small register bus with 4-bit data. It clears a flag by writing 1 to that flag's bit.

The block combines the pending requests with the CPU interrupt-enable flag and drives a single maskable request line. A separate non-maskable request is latched from the rising edge of a dedicated source and is held until the CPU acknowledges it. Both request lines are held back until the CPU has written both of its stack-pointer registers. They are held back again whenever only one of the pair has been rewritten, until its partner is written too.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset every enable bit and every request flag reads 0, `irq_req` and `nmi_req` are 0, and the stack-pointer pair counts as not written.
- R2: An event pulse sets its request flag on the next clock edge, whatever the state of its enable bit.
- R3: A bus write to a flag address clears each flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R4: The enable bits sit at addresses E2h, E3h, E4h, E6h and E7h, and the matching flags sit 10h above them. The bits are: programmable timer D1..D0 at E2h; serial D0 at E3h; key input D0 at E4h; clock timer D3..D0 at E6h; stopwatch D1..D0 at E7h. An enable-bit write stores the data bits and reads back unchanged.
- R5: Unimplemented bit positions, unimplemented addresses, and any read with `bus_rd` low return 0.
- R6: `irq_req` is 1 exactly when some flag and its enable bit are both 1, `cpu_iflag` is 1 and the stack-pointer pair is valid. It stays 1 across interrupt re-enabling until the flag is cleared.
- R7: From reset, neither `irq_req` nor `nmi_req` is raised until both `sp1_wr` and `sp2_wr` have been pulsed.
- R8: A write to only one of the two stack pointers blocks both request lines. They stay blocked until the other one is written.
- R9: A rising edge on `nmi_src` latches a pending NMI. The pending NMI is shown on `nmi_req` only while the pair is valid, and `nmi_ack` clears it.
- R10: When an event and a write-1 clear reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address (low byte) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, combinational |
| ev_ptm | input | 2 | Programmable timer event pulses |
| ev_sif | input | 1 | Serial interface event pulse |
| ev_key | input | 1 | Key input event pulse |
| ev_ctm | input | 4 | Clock timer event pulses |
| ev_swt | input | 2 | Stopwatch event pulses |
| nmi_src | input | 1 | Non-maskable source level (rising edge latched) |
| nmi_ack | input | 1 | CPU acknowledge of the NMI |
| cpu_iflag | input | 1 | CPU interrupt-enable flag |
| sp1_wr | input | 1 | First stack-pointer write strobe |
| sp2_wr | input | 1 | Second stack-pointer write strobe |
| irq_req | output | 1 | Maskable interrupt request |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The request path is tried in four ways: with an event whose enable bit is 0, which shows that capture does not depend on the enable bit; with flag and enable both set while `cpu_iflag` toggles, which shows that the request persists until the flag is cleared; with stack-pointer writes given in full pairs, as a lone write and as a repeated lone write, which shows that blocking applies to both request lines; and with an event that collides with a clear, which shows that the event takes priority. Walking every enable address with all-ones data, together with reads of empty addresses and reads with the strobe low, separates the implemented bit layout from the bits that must read 0.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 4;
    localparam int N_GRP      = 5;
    localparam logic [ADDR_W-1:0] EN_BASE   = 8'hE0;
    localparam logic [ADDR_W-1:0] FLAG_STEP = 8'h10;

    // Number of event bits in each group.
    function automatic int grp_width(input int g);
        case (g)
            0:       return 2;  // programmable timer
            1:       return 1;  // serial
            2:       return 1;  // key input
            3:       return 4;  // clock timer
            default: return 2;  // stopwatch
        endcase
    endfunction

    // Low-nibble address offset of each group.
    function automatic int grp_offset(input int g);
        case (g)
            0:       return 2;
            1:       return 3;
            2:       return 4;
            3:       return 6;
            default: return 7;
        endcase
    endfunction

    // Position of a group's first bit in the packed event vector.
    function automatic int grp_lsb(input int g);
        int s;
        s = 0;
        for (int i = 0; i < g; i++) s += grp_width(i);
        return s;
    endfunction

    localparam int N_SRC = grp_lsb(N_GRP);

    typedef struct packed {
        logic first_done;
        logic second_done;
    } sp_pair_t;

endpackage

// File: rtl/irq_src_group.sv
module irq_src_group
    import irq_ctrl_pkg::*;
#(
    parameter int W = 2,
    parameter logic [ADDR_W-1:0] EN_ADDR   = 8'hE2,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'hF2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [W-1:0]      ev,
    output logic              pend,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] IMPL = DATA_W'((1 << W) - 1);

    logic [DATA_W-1:0] en_q, flag_q, ev_ext, clr_bits;

    assign ev_ext   = DATA_W'(ev);
    assign clr_bits = (bus_wr && bus_addr == FLAG_ADDR) ? (bus_wdata & IMPL) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            if (bus_wr && bus_addr == EN_ADDR)
                en_q <= bus_wdata & IMPL;
            // event wins over a simultaneous clear
            flag_q <= ((flag_q & ~clr_bits) | ev_ext) & IMPL;
        end
    end

    assign pend = |(flag_q & en_q);

    always_comb begin
        rdata = '0;
        if (bus_rd && bus_addr == EN_ADDR)   rdata = en_q;
        if (bus_rd && bus_addr == FLAG_ADDR) rdata = flag_q;
    end

    p_event_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
        (|ev) |=> ((flag_q & $past(ev_ext)) == $past(ev_ext)));

    p_write_one_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == FLAG_ADDR && ev == '0)
        |=> ((flag_q & $past(bus_wdata)) == '0));

    p_collision_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (|(ev_ext & clr_bits)) |=> ((flag_q & $past(ev_ext & clr_bits)) != '0));

endmodule

// File: rtl/irq_sp_guard.sv
module irq_sp_guard
    import irq_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sp1_wr,
    input  logic sp2_wr,
    output logic pair_ok
);
    sp_pair_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (sp1_wr && sp2_wr) begin
            st_d.first_done  = 1'b1;
            st_d.second_done = 1'b1;
        end else if (sp1_wr) begin
            st_d.first_done  = 1'b1;
            // a fresh half-pair invalidates the partner
            if (st_q.first_done) st_d.second_done = 1'b0;
        end else if (sp2_wr) begin
            st_d.second_done = 1'b1;
            if (st_q.second_done) st_d.first_done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pair_ok = st_q.first_done & st_q.second_done;

    p_lone_sp1_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        (sp1_wr && !sp2_wr && st_q.first_done) |=> !pair_ok);

    p_lone_sp2_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        (sp2_wr && !sp1_wr && st_q.second_done) |=> !pair_ok);

    p_both_written_ok_r7: assert property (@(posedge clk) disable iff (rst)
        (sp1_wr && sp2_wr) |=> pair_ok);

endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_src,
    input  logic nmi_ack,
    input  logic pair_ok,
    output logic nmi_req
);
    logic src_q, pend_q, rise;

    assign rise = nmi_src & ~src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            src_q <= nmi_src;
            if (rise)         pend_q <= 1'b1;
            else if (nmi_ack) pend_q <= 1'b0;
        end
    end

    assign nmi_req = pend_q & pair_ok;

    p_edge_latched_r9: assert property (@(posedge clk) disable iff (rst)
        rise |=> pend_q);

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (nmi_ack && !rise) |=> !pend_q);

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        ev_ptm,
    input  logic              ev_sif,
    input  logic              ev_key,
    input  logic [3:0]        ev_ctm,
    input  logic [1:0]        ev_swt,
    input  logic              nmi_src,
    input  logic              nmi_ack,
    input  logic              cpu_iflag,
    input  logic              sp1_wr,
    input  logic              sp2_wr,
    output logic              irq_req,
    output logic              nmi_req
);
    logic [N_SRC-1:0]  ev_all;
    logic [N_GRP-1:0]  grp_pend;
    logic [DATA_W-1:0] grp_rd [N_GRP];
    logic              pair_ok;

    assign ev_all = {ev_swt, ev_ctm, ev_key, ev_sif, ev_ptm};

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam int GW  = grp_width(g);
        localparam int LSB = grp_lsb(g);
        localparam logic [ADDR_W-1:0] EA = EN_BASE + ADDR_W'(grp_offset(g));

        irq_src_group #(
            .W         (GW),
            .EN_ADDR   (EA),
            .FLAG_ADDR (EA + FLAG_STEP)
        ) u_grp (
            .clk       (clk),
            .rst       (rst),
            .bus_addr  (bus_addr),
            .bus_wr    (bus_wr),
            .bus_rd    (bus_rd),
            .bus_wdata (bus_wdata),
            .ev        (ev_all[LSB +: GW]),
            .pend      (grp_pend[g]),
            .rdata     (grp_rd[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < N_GRP; g++) bus_rdata |= grp_rd[g];
    end

    irq_sp_guard u_guard (
        .clk     (clk),
        .rst     (rst),
        .sp1_wr  (sp1_wr),
        .sp2_wr  (sp2_wr),
        .pair_ok (pair_ok)
    );

    irq_nmi_latch u_nmi (
        .clk     (clk),
        .rst     (rst),
        .nmi_src (nmi_src),
        .nmi_ack (nmi_ack),
        .pair_ok (pair_ok),
        .nmi_req (nmi_req)
    );

    assign irq_req = (|grp_pend) & cpu_iflag & pair_ok;

    p_reset_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_req && !nmi_req));

    p_request_persists_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !bus_wr && !sp1_wr && !sp2_wr) ##1 cpu_iflag |-> irq_req);

endmodule

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_addr;
    logic       bus_wr, bus_rd;
    logic [3:0] bus_wdata, bus_rdata;
    logic [1:0] ev_ptm, ev_swt;
    logic       ev_sif, ev_key;
    logic [3:0] ev_ctm;
    logic       nmi_src, nmi_ack, cpu_iflag, sp1_wr, sp2_wr;
    logic       irq_req, nmi_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_flag_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_ptm(ev_ptm), .ev_sif(ev_sif),
        .ev_key(ev_key), .ev_ctm(ev_ctm), .ev_swt(ev_swt), .nmi_src(nmi_src),
        .nmi_ack(nmi_ack), .cpu_iflag(cpu_iflag), .sp1_wr(sp1_wr), .sp2_wr(sp2_wr),
        .irq_req(irq_req), .nmi_req(nmi_req)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [3:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic pulse_sp(input bit one, input bit two);
        @(negedge clk);
        sp1_wr = one; sp2_wr = two;
        @(negedge clk);
        sp1_wr = 1'b0; sp2_wr = 1'b0;
    endtask

    task automatic pulse_nmi();
        @(negedge clk); nmi_src = 1'b1;
        @(negedge clk); nmi_src = 1'b0;
    endtask

    task automatic ack_nmi();
        @(negedge clk); nmi_ack = 1'b1;
        @(negedge clk); nmi_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [3:0] v;
        for (int a = 8'hE2; a <= 8'hF7; a++) begin
            rd(8'(a), v);
            check("R1 reset register", v, 4'h0);
        end
        check("R1 irq_req after reset", {3'b0, irq_req}, 4'h0);
        check("R1 nmi_req after reset", {3'b0, nmi_req}, 4'h0);
    endtask

    task automatic t_pair_from_reset();
        cpu_iflag = 1'b1;
        wr(8'hE7, 4'h1);
        @(negedge clk); ev_swt = 2'b01;
        @(negedge clk); ev_swt = 2'b00;
        pulse_nmi();
        check("R7 irq blocked before SP writes", {3'b0, irq_req}, 4'h0);
        check("R7 nmi blocked before SP writes", {3'b0, nmi_req}, 4'h0);
        pulse_sp(1, 0);
        check("R7 irq blocked after SP1 only", {3'b0, irq_req}, 4'h0);
        check("R7 nmi blocked after SP1 only", {3'b0, nmi_req}, 4'h0);
        pulse_sp(0, 1);
        check("R7 irq after pair", {3'b0, irq_req}, 4'h1);
        check("R9 nmi shown once pair valid", {3'b0, nmi_req}, 4'h1);
        ack_nmi();
        check("R9 nmi cleared by ack", {3'b0, nmi_req}, 4'h0);
        wr(8'hF7, 4'h1);
        check("R3 irq drops after clear", {3'b0, irq_req}, 4'h0);
        wr(8'hE7, 4'h0);
    endtask

    task automatic t_flag_without_enable();
        logic [3:0] v;
        @(negedge clk); ev_ctm = 4'b0100;
        @(negedge clk); ev_ctm = 4'b0000;
        rd(8'hF6, v);
        check("R2 flag set with enable 0", v, 4'h4);
        check("R6 no irq with enable 0", {3'b0, irq_req}, 4'h0);
        wr(8'hF6, 4'h0);
        rd(8'hF6, v);
        check("R3 write 0 keeps flag", v, 4'h4);
        wr(8'hF6, 4'h4);
        rd(8'hF6, v);
        check("R3 write 1 clears flag", v, 4'h0);
    endtask

    task automatic t_layout();
        logic [3:0] v;
        logic [3:0] expv [8] = '{4'h0, 4'h0, 4'h3, 4'h1, 4'h1, 4'h0, 4'hF, 4'h3};
        for (int o = 2; o < 8; o++) wr(8'hE0 + 8'(o), 4'hF);
        for (int o = 2; o < 8; o++) begin
            rd(8'hE0 + 8'(o), v);
            check("R4 enable readback layout", v, expv[o]);
        end
        rd(8'hE0, v);  check("R5 unused address reads 0", v, 4'h0);
        rd(8'hF5, v);  check("R5 unused flag address reads 0", v, 4'h0);
        bus_addr = 8'hE6; #1;
        check("R5 no read strobe returns 0", bus_rdata, 4'h0);
        for (int o = 2; o < 8; o++) wr(8'hE0 + 8'(o), 4'h0);
    endtask

    task automatic t_request_gating();
        wr(8'hE2, 4'h2);
        @(negedge clk); ev_ptm = 2'b10;
        @(negedge clk); ev_ptm = 2'b00;
        check("R6 irq with flag, enable, iflag", {3'b0, irq_req}, 4'h1);
        cpu_iflag = 1'b0; #1;
        check("R6 irq masked by iflag", {3'b0, irq_req}, 4'h0);
        @(negedge clk); cpu_iflag = 1'b1; #1;
        check("R6 irq raised again on re-enable", {3'b0, irq_req}, 4'h1);
        wr(8'hF2, 4'h2);
        check("R6 irq gone after flag clear", {3'b0, irq_req}, 4'h0);
        wr(8'hE2, 4'h0);
    endtask

    task automatic t_single_sp();
        wr(8'hE6, 4'h1);
        @(negedge clk); ev_ctm = 4'b0001;
        @(negedge clk); ev_ctm = 4'b0000;
        check("R8 irq before lone write", {3'b0, irq_req}, 4'h1);
        pulse_sp(0, 1);
        check("R8 irq blocked after lone SP2", {3'b0, irq_req}, 4'h0);
        pulse_nmi();
        check("R8 nmi blocked after lone SP2", {3'b0, nmi_req}, 4'h0);
        pulse_sp(0, 1);
        check("R8 still blocked after repeated SP2", {3'b0, irq_req}, 4'h0);
        pulse_sp(1, 0);
        check("R8 irq restored by partner", {3'b0, irq_req}, 4'h1);
        check("R8 nmi restored by partner", {3'b0, nmi_req}, 4'h1);
        ack_nmi();
        wr(8'hF6, 4'h1);
        wr(8'hE6, 4'h0);
    endtask

    task automatic t_collision();
        logic [3:0] v;
        @(negedge clk);
        ev_key = 1'b1; bus_addr = 8'hF4; bus_wdata = 4'h1; bus_wr = 1'b1;
        @(negedge clk);
        ev_key = 1'b0; bus_wr = 1'b0;
        rd(8'hF4, v);
        check("R10 event beats clear", v, 4'h1);
        wr(8'hF4, 4'h1);
        rd(8'hF4, v);
        check("R10 later clear works", v, 4'h0);
    endtask

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
        ev_ptm = '0; ev_sif = 0; ev_key = 0; ev_ctm = '0; ev_swt = '0;
        nmi_src = 0; nmi_ack = 0; cpu_iflag = 0; sp1_wr = 0; sp2_wr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pair_from_reset();
        t_flag_without_enable();
        t_layout();
        t_request_gating();
        t_single_sp();
        t_collision();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule